// File: doc/BRIEF.md
# Serial Multi-Byte Data Word Loader

This block takes a serial write of a 24-bit data word and commits it atomically. Serial clock, active-low chip select and serial data come from outside and are first synchronised into the system clock domain. Edges of the serial clock are then detected there. Data bits are captured on rising serial-clock edges. A two-bit byte-count selector sets whether the write carries one, two or three bytes. Bytes always arrive upper byte first, starting with bits 23:16. A bit-order input sets whether the bits inside each byte come most significant first or least significant first.

Captured bytes wait in a staging area. On the falling serial-clock edge that ends the last bit of the last byte, they are merged into the committed word in one step. Bytes that the write did not carry keep their old values. At the same moment a one-cycle load strobe is raised toward the downstream modulator. A commit happens only in normal mode. A format input selects how the word is presented: in converting mode, bit 23 of the output is inverted, which maps between offset two's complement and straight binary.

Top module: `ser_word_loader`

## Requirements
- R1: After reset, `word_o` is 0 (with `fmt_sel_i` = 0) and `load_o` is 0.
- R2: With `nbyte_sel_i` = 2'b10, 24 bits are received as byte 2 (bits 23:16), byte 1 and byte 0. Each byte is most significant bit first when `lsb_first_i` = 0. The full word is committed.
- R3: With `lsb_first_i` = 1, each byte is received least significant bit first, while the byte order stays the same.
- R4: `nbyte_sel_i` = 2'b00 replaces only bits 23:16, and 2'b01 replaces only bits 23:8. The remaining bits keep their previous values.
- R5: `nbyte_sel_i` = 2'b11 behaves as a three-byte write.
- R6: `word_o` does not change before the final falling serial-clock edge of a write. Word and strobe appear 3 system-clock cycles after that edge at the pin. `word_o` changes only together with `load_o`, unless `fmt_sel_i` changes.
- R7: If `csn_i` rises before the last bit of a write, the partial data is discarded, `word_o` is unchanged and no strobe is issued.
- R8: When `mode_i` is not 2'b00 (01 = self-calibration, 10 = sleep, 11 = reserved), a completed write neither changes the word nor raises `load_o`.
- R9: With `fmt_sel_i` = 1, `word_o` equals the committed word with bit 23 inverted. This applies in the same cycle.
- R10: `load_o` is high for exactly one system-clock cycle per commit.
- R11: Serial bits sent after a write has completed are ignored until `csn_i` is deasserted. They cause no second commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| csn_i | input | 1 | Active-low chip select (asynchronous) |
| sdi_i | input | 1 | Serial data in |
| nbyte_sel_i | input | 2 | Byte count: 00=1, 01=2, 10/11=3 |
| lsb_first_i | input | 1 | 0 = MSB first within a byte, 1 = LSB first |
| fmt_sel_i | input | 1 | 1 = invert bit 23 on the output |
| mode_i | input | 2 | 00 normal, 01 self-cal, 10 sleep, 11 reserved |
| word_o | output | 24 | Committed word toward the modulator |
| load_o | output | 1 | One-cycle load strobe |

## Verification
Both the committed word and the strobe are due exactly three system-clock cycles after the bench drives the final falling serial-clock edge: two synchroniser stages plus the edge-detect and commit register. When the driver drives that edge, it pushes the expected word together with its due cycle. The monitor samples on falling system-clock edges, pops an entry on each strobe, and compares both the word and the arrival cycle. Any strobe that arrives with an empty queue is an error. Aborted, non-normal and overrun transfers push nothing, and the bench reads the word back at the port after each of them.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int BYTE_W = 8;
  localparam int NBYTES = 3;
  localparam int WORD_W = BYTE_W * NBYTES;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_SELFCAL = 2'b01,
    MODE_SLEEP   = 2'b10,
    MODE_RSVD    = 2'b11
  } mode_e;
endpackage

// File: rtl/swl_sync.sv
module swl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/swl_shifter.sv
module swl_shifter #(
  parameter int BYTE_W = swl_pkg::BYTE_W,
  parameter int NBYTES = swl_pkg::NBYTES,
  parameter int WORD_W = BYTE_W * NBYTES,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic              lsb_first_i,
  input  logic [1:0]        nbyte_sel_i,
  output logic [WORD_W-1:0] stage_o,
  output logic [NBYTES-1:0] mask_o,
  output logic              commit_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int IDX_W = CNT_W - BIT_W;

  logic [CNT_W-1:0]  cnt_q, cnt_d, nbits;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic              fired_q, fired_d;
  logic              done, take, byte_end;
  logic [IDX_W-1:0]  pos;

  always_comb begin
    case (nbyte_sel_i)
      2'b00:   nbits = CNT_W'(BYTE_W);
      2'b01:   nbits = CNT_W'(2 * BYTE_W);
      default: nbits = CNT_W'(NBYTES * BYTE_W);
    endcase
  end

  assign done     = (cnt_q == nbits);
  assign take     = cs_act_i && rise_i && !done;
  assign byte_end = take && (cnt_q[BIT_W-1:0] == BIT_W'(BYTE_W - 1));
  assign pos      = IDX_W'(NBYTES - 1) - cnt_q[CNT_W-1:BIT_W];
  assign commit_o = cs_act_i && fall_i && done && !fired_q;

  always_comb begin
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    fired_d = fired_q;
    if (!cs_act_i) begin
      cnt_d   = '0;
      fired_d = 1'b0;
    end else begin
      if (take) begin
        sr_d  = lsb_first_i ? {sdi_i, sr_q[BYTE_W-1:1]} : {sr_q[BYTE_W-2:0], sdi_i};
        cnt_d = cnt_q + CNT_W'(1);
      end
      if (commit_o) fired_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sr_q    <= '0;
      fired_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
      if (take) sr_q <= sr_d;
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic wr_en;
    assign wr_en = byte_end && (pos == IDX_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_o[b*BYTE_W +: BYTE_W] <= '0;
        mask_o[b]                   <= 1'b0;
      end else begin
        if (wr_en) stage_o[b*BYTE_W +: BYTE_W] <= sr_d;
        if (!cs_act_i)  mask_o[b] <= 1'b0;
        else if (wr_en) mask_o[b] <= 1'b1;
      end
    end
  end

  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/swl_commit.sv
module swl_commit #(
  parameter int BYTE_W = swl_pkg::BYTE_W,
  parameter int NBYTES = swl_pkg::NBYTES,
  parameter int WORD_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [1:0]        mode_i,
  input  logic [WORD_W-1:0] stage_i,
  input  logic [NBYTES-1:0] mask_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);
  import swl_pkg::*;

  logic [WORD_W-1:0] word_d;
  logic              commit_en;

  assign commit_en = commit_i && (mode_e'(mode_i) == MODE_NORMAL);

  for (genvar b = 0; b < NBYTES; b++) begin : g_merge
    assign word_d[b*BYTE_W +: BYTE_W] = mask_i[b] ? stage_i[b*BYTE_W +: BYTE_W]
                                                  : word_o[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      load_o <= 1'b0;
    end else begin
      load_o <= commit_en;
      if (commit_en) word_o <= word_d;
    end
  end
endmodule

// File: rtl/ser_word_loader.sv
module ser_word_loader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_i,
  input  logic        csn_i,
  input  logic        sdi_i,
  input  logic [1:0]  nbyte_sel_i,
  input  logic        lsb_first_i,
  input  logic        fmt_sel_i,
  input  logic [1:0]  mode_i,
  output logic [23:0] word_o,
  output logic        load_o
);
  import swl_pkg::*;

  logic [2:0]        raw, synced;
  logic              sclk_s, csn_s, sdi_s, sclk_q;
  logic              rise, fall, cs_act, commit;
  logic [WORD_W-1:0] stage, word_q;
  logic [NBYTES-1:0] mask;
  logic [CNT_W-1:0]  bit_cnt;

  assign raw = {csn_i, sclk_i, sdi_i};

  swl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
  );

  assign {csn_s, sclk_s, sdi_s} = synced;
  assign cs_act = !csn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign rise = sclk_s && !sclk_q;
  assign fall = !sclk_s && sclk_q;

  swl_shifter #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act_i(cs_act), .rise_i(rise), .fall_i(fall),
    .sdi_i(sdi_s), .lsb_first_i(lsb_first_i), .nbyte_sel_i(nbyte_sel_i),
    .stage_o(stage), .mask_o(mask), .commit_o(commit), .bit_cnt_o(bit_cnt)
  );

  swl_commit #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_commit (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .mode_i(mode_i),
    .stage_i(stage), .mask_i(mask), .word_o(word_q), .load_o(load_o)
  );

  assign word_o = fmt_sel_i ? {~word_q[WORD_W-1], word_q[WORD_W-2:0]} : word_q;
endmodule

// File: rtl/swl_chk.sv
module swl_chk #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_o,
  input logic [WORD_W-1:0] word_o,
  input logic [1:0]        mode_i,
  input logic              fmt_sel_i,
  input logic              cs_act,
  input logic [CNT_W-1:0]  bit_cnt
);
  assert_load_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  assert_load_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> ($past(mode_i) == 2'b00));

  assert_load_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> $past(cs_act));

  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_o && $stable(fmt_sel_i)) |-> $stable(word_o));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));
endmodule

bind ser_word_loader swl_chk #(.WORD_W(24), .CNT_W(swl_pkg::CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_o(load_o), .word_o(word_o), .mode_i(mode_i),
  .fmt_sel_i(fmt_sel_i), .cs_act(cs_act), .bit_cnt(bit_cnt)
);

// File: tb/sim_ser_word_loader.sv
module sim_ser_word_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [1:0]  nsel = 2'b10, mode = 2'b00;
  logic        lsbf = 1'b0, fmt = 1'b0;
  logic [23:0] word;
  logic        load;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;
  logic [23:0] model = '0;
  logic [23:0] exp_q[$];
  int          due_q[$];
  logic        load_prev = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  ser_word_loader u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .nbyte_sel_i(nsel), .lsb_first_i(lsbf), .fmt_sel_i(fmt), .mode_i(mode),
    .word_o(word), .load_o(load)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops one expected word per strobe, checks value and arrival cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (load && load_prev) check("R10 strobe width", 1, 0);
      if (load) begin
        if (exp_q.size() == 0) check("R7/R8/R11 unexpected strobe", 1, 0);
        else begin
          logic [23:0] e;
          int d;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          check("R2 committed word", word, e);
          check("R6 strobe latency", cyc, d);
        end
      end
      load_prev = load;
    end
  end

  // driver: sends nsend bits of data starting at byte 2
  task automatic xfer(input logic [1:0] cnt, input logic lsb, input logic [1:0] md,
                      input logic [23:0] data, input int nsend, input bit expect_load);
    int nb;
    logic [23:0] nxt;
    nb = (cnt == 2'b00) ? 1 : (cnt == 2'b01) ? 2 : 3;
    nxt = model;
    for (int k = 0; k < nb; k++) nxt[23-8*k -: 8] = data[23-8*k -: 8];
    nsel = cnt; lsbf = lsb; mode = md;
    csn = 1'b0;
    waitn(4);
    for (int i = 0; i < nsend; i++) begin
      logic [7:0] bv;
      bv = data[23-8*((i/8)%3) -: 8];
      sdi = lsb ? bv[i%8] : bv[7-(i%8)];
      waitn(3);
      sclk = 1'b1;
      waitn(6);
      if (expect_load && i == nb*8-1) begin
        check("R6 word held before final edge", word, model);
        exp_q.push_back(nxt);
        due_q.push_back(cyc + 3);
      end
      sclk = 1'b0;
      waitn(3);
    end
    waitn(8);
    csn = 1'b1;
    waitn(8);
    if (expect_load) model = nxt;
  endtask

  initial begin
    waitn(3);
    check("R1 reset word", word, 0);
    check("R1 reset strobe", load, 0);
    rst_n = 1'b1;
    waitn(4);
    // R2: three bytes MSB first
    xfer(2'b10, 1'b0, 2'b00, 24'hA53C0F, 24, 1);
    check("R2 word after write", word, 24'hA53C0F);
    // R3: LSB-first bit order
    xfer(2'b10, 1'b1, 2'b00, 24'h12B456, 24, 1);
    check("R3 lsb-first word", word, 24'h12B456);
    // R4: one byte then two bytes
    xfer(2'b00, 1'b0, 2'b00, 24'h9E0000, 8, 1);
    check("R4 one-byte write", word, 24'h9EB456);
    xfer(2'b01, 1'b1, 2'b00, 24'h778800, 16, 1);
    check("R4 two-byte write", word, 24'h778856);
    // R5: selector 11 acts as three bytes
    xfer(2'b11, 1'b0, 2'b00, 24'hC1D2E3, 24, 1);
    check("R5 sel 11 three bytes", word, 24'hC1D2E3);
    // R7: abort after 12 bits
    xfer(2'b10, 1'b0, 2'b00, 24'h00FF00, 12, 0);
    check("R7 abort keeps word", word, 24'hC1D2E3);
    // R8: non-normal modes
    xfer(2'b10, 1'b0, 2'b10, 24'h111111, 24, 0);
    check("R8 sleep keeps word", word, 24'hC1D2E3);
    xfer(2'b10, 1'b0, 2'b01, 24'h222222, 24, 0);
    check("R8 selfcal keeps word", word, 24'hC1D2E3);
    xfer(2'b10, 1'b0, 2'b11, 24'h333333, 24, 0);
    check("R8 reserved keeps word", word, 24'hC1D2E3);
    // R11: extra bits after a one-byte write are ignored
    xfer(2'b00, 1'b0, 2'b00, 24'h5AFF00, 16, 1);
    check("R11 overrun ignored", word, 24'h5AD2E3);
    // R9: format conversion on output
    @(negedge clk);
    fmt = 1'b1;
    #1;
    check("R9 format inverts bit 23", word, 24'hDAD2E3);
    waitn(2);
    fmt = 1'b0;
    #1;
    check("R9 format off", word, 24'h5AD2E3);
    waitn(4);
    check("R6 no pending strobes", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule